// File: doc/BRIEF.md
# Programmable Small-Integer Tag Codec

This datapath block sits in front of and behind an integer ALU so that one ALU can serve several dynamic-language tagging conventions. Two identical strip lanes take operands A and B, decide from a programmable table whether each word is a legal tagged small integer, and turn it into a plain two's-complement integer. A single rebuild lane takes the ALU result and packs it back into a tagged word. It flags the result when that word cannot be represented.

The convention is held in one 32-bit configuration word that software loads through a write port. The word has four fields:
- `legal` (bits 15:0): a 16-entry validity table, indexed by the four tag-relevant bits {bit31, bit30, bit1, bit0} of a word.
- `keep` (bits 19:16): a mask ANDed onto those four bits when stripping a tag.
- `set` (bits 23:20): a mask ORed onto them when rebuilding a tag.
- `shamt` (bits 25:24): a 2-bit shift count.

Bits 31:26 are don't-care. Typical settings:
- 0x011EAAAA: odd words are integers, shift 1.
- 0x020F1111: low two bits 00, shift 2.
- 0x000FF00F: top two bits equal, no shift. This is the reset value.

All outputs are registered, so they appear one clock after their inputs.

Top module: `smallint_tag_unit`

## Requirements
- R1: After reset (synchronous, active-low `rst_n`) all outputs are 0 and the configuration equals 0x000FF00F.
- R2: A lane's `_ok` output is bit N of config[15:0], where N = {w[31], w[30], w[1], w[0]} (w[31] is the MSB of N).
- R3: When stripping, bits 31, 30, 1 and 0 of the operand are ANDed with config bits 19, 18, 17 and 16 respectively; all other bits pass unchanged.
- R4: After masking, the stripped value is shifted right arithmetically by config[25:24].
- R5: The rebuilt word is the ALU result shifted left by config[25:24], with bits 31, 30, 1 and 0 then ORed with config bits 23, 22, 21 and 20.
- R6: `res_ovf` is 1 when the signed ALU result times 2^config[25:24] lies outside the signed 32-bit range.
- R7: `res_ovf` is 1 when the rebuilt word's table entry (as in R2) is 0.
- R8: Outputs reflect the inputs of the previous clock edge. A configuration write at an edge affects results from the next edge on; an operand presented in the same cycle as the write uses the old configuration.
- R9: Config bits 31:26 have no effect on any output.
- R10: Lanes A and B behave identically and independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration word to load |
| opa | input | 32 | Tagged operand A |
| opb | input | 32 | Tagged operand B |
| alu_res | input | 32 | Untagged ALU result to rebuild |
| opa_raw | output | 32 | Stripped operand A |
| opa_ok | output | 1 | Operand A is a legal small integer |
| opb_raw | output | 32 | Stripped operand B |
| opb_ok | output | 1 | Operand B is a legal small integer |
| res_word | output | 32 | Rebuilt tagged result |
| res_ovf | output | 1 | Result cannot be represented as a tagged integer |

## Verification
A configuration write and the processing of operands can happen in the same cycle. The bench does this often, on purpose: convention switches are issued together with live operands and results, both in the directed phases and in the random phase. The reference model applies the write only after it has computed that cycle's expectation from the old convention. Any early use of the new word therefore shows up as a mismatch on the strip and rebuild outputs of that cycle.

// File: rtl/tag_pkg.sv
// Package: shared widths, the configuration layout and its reset value
// for the small-integer tag codec. Assumes a 32-bit configuration word.
package tag_pkg;
    localparam int TAG_BITS    = 4;
    localparam int TBL_ENTRIES = 1 << TAG_BITS;
    localparam int SHIFT_W     = 2;
    localparam int CFG_W       = 32;
    localparam int SPARE_W     = CFG_W - TBL_ENTRIES - 2 * TAG_BITS - SHIFT_W;

    // Field order from MSB down matches the bit positions software writes.
    typedef struct packed {
        logic [SPARE_W-1:0]     spare;
        logic [SHIFT_W-1:0]     shamt;
        logic [TAG_BITS-1:0]    set_m;
        logic [TAG_BITS-1:0]    keep_m;
        logic [TBL_ENTRIES-1:0] legal;
    } tag_cfg_t;

    localparam logic [CFG_W-1:0] CFG_RESET = 32'h000F_F00F;
endpackage

// File: rtl/tag_cfg_reg.sv
// Module: holds the tag convention word. Assumes synchronous active-low
// reset; the spare bits are never stored, so they cannot reach any logic.
module tag_cfg_reg
    import tag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output tag_cfg_t         cfg_o
);
    tag_cfg_t wr_cfg;

    // Drop the spare field of the incoming word.
    always_comb begin
        wr_cfg       = tag_cfg_t'(wr_data);
        wr_cfg.spare = '0;
    end

    // Load the convention on a write, restore the default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= tag_cfg_t'(CFG_RESET);
        end else if (wr_en) begin
            cfg_o <= wr_cfg;
        end
    end
endmodule

// File: rtl/tag_detag.sv
// Module: one strip lane. Checks an operand against the validity table,
// masks its four tag bits and shifts it right arithmetically.
// Combinational; assumes DATA_W >= 4.
module tag_detag
    import tag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  tag_cfg_t          cfg_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] raw_o,
    output logic              legal_o
);
    localparam int HI = DATA_W - 1;
    localparam int NH = DATA_W - 2;

    logic [TAG_BITS-1:0] idx;
    logic [DATA_W-1:0]   masked;

    // Gather the tag-relevant bits into a table index.
    always_comb idx = {word_i[HI], word_i[NH], word_i[1], word_i[0]};

    // Look up legality of the tag combination.
    always_comb legal_o = cfg_i.legal[idx];

    // Clear tag bits selected by the keep mask.
    always_comb begin
        masked     = word_i;
        masked[HI] = word_i[HI] & cfg_i.keep_m[3];
        masked[NH] = word_i[NH] & cfg_i.keep_m[2];
        masked[1]  = word_i[1]  & cfg_i.keep_m[1];
        masked[0]  = word_i[0]  & cfg_i.keep_m[0];
    end

    // Scale the masked word down, keeping its sign.
    always_comb raw_o = DATA_W'($signed(masked) >>> cfg_i.shamt);
endmodule

// File: rtl/tag_retag.sv
// Module: the rebuild lane. Shifts an ALU result left, ORs in the tag
// bits and reports overflow on lost significance or an illegal tag.
// Combinational; assumes DATA_W >= 4.
module tag_retag
    import tag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  tag_cfg_t          cfg_i,
    input  logic [DATA_W-1:0] value_i,
    output logic [DATA_W-1:0] word_o,
    output logic              ovf_o
);
    localparam int HI = DATA_W - 1;
    localparam int NH = DATA_W - 2;

    logic [DATA_W-1:0]   shifted;
    logic [DATA_W-1:0]   back;
    logic                lost;
    logic [TAG_BITS-1:0] idx;

    // Scale the result up to make room for the tag.
    always_comb shifted = value_i << cfg_i.shamt;

    // Undo the scaling; any difference means bits fell off the top.
    always_comb begin
        back = DATA_W'($signed(shifted) >>> cfg_i.shamt);
        lost = (back != value_i);
    end

    // Force tag bits selected by the set mask.
    always_comb begin
        word_o     = shifted;
        word_o[HI] = shifted[HI] | cfg_i.set_m[3];
        word_o[NH] = shifted[NH] | cfg_i.set_m[2];
        word_o[1]  = shifted[1]  | cfg_i.set_m[1];
        word_o[0]  = shifted[0]  | cfg_i.set_m[0];
    end

    // Flag a result that lost bits or carries an illegal tag.
    always_comb begin
        idx   = {word_o[HI], word_o[NH], word_o[1], word_o[0]};
        ovf_o = lost | ~cfg_i.legal[idx];
    end
endmodule

// File: rtl/smallint_tag_unit.sv
// Module: top of the tag codec. One configuration register, NUM_SRC strip
// lanes for the ALU operands and one rebuild lane for the result; every
// output is registered. Assumes synchronous active-low reset.
module smallint_tag_unit
    import tag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] alu_res,
    output logic [DATA_W-1:0] opa_raw,
    output logic              opa_ok,
    output logic [DATA_W-1:0] opb_raw,
    output logic              opb_ok,
    output logic [DATA_W-1:0] res_word,
    output logic              res_ovf
);
    localparam int NUM_SRC = 2;

    tag_cfg_t          cfg;
    logic [DATA_W-1:0] src_word [NUM_SRC];
    logic [DATA_W-1:0] src_raw  [NUM_SRC];
    logic              src_ok   [NUM_SRC];
    logic [DATA_W-1:0] raw_q    [NUM_SRC];
    logic              ok_q     [NUM_SRC];
    logic [DATA_W-1:0] rt_word;
    logic              rt_ovf;

    tag_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_o   (cfg)
    );

    // Route the operands onto the lane array.
    always_comb begin
        src_word[0] = opa;
        src_word[1] = opb;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
        tag_detag #(.DATA_W(DATA_W)) u_detag (
            .cfg_i   (cfg),
            .word_i  (src_word[g]),
            .raw_o   (src_raw[g]),
            .legal_o (src_ok[g])
        );

        // Register this lane's stripped value and legality.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q[g] <= '0;
                ok_q[g]  <= 1'b0;
            end else begin
                raw_q[g] <= src_raw[g];
                ok_q[g]  <= src_ok[g];
            end
        end
    end

    tag_retag #(.DATA_W(DATA_W)) u_retag (
        .cfg_i   (cfg),
        .value_i (alu_res),
        .word_o  (rt_word),
        .ovf_o   (rt_ovf)
    );

    // Register the rebuilt result and its overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_word <= '0;
            res_ovf  <= 1'b0;
        end else begin
            res_word <= rt_word;
            res_ovf  <= rt_ovf;
        end
    end

    // Present the lane registers on the named ports.
    always_comb begin
        opa_raw = raw_q[0];
        opa_ok  = ok_q[0];
        opb_raw = raw_q[1];
        opb_ok  = ok_q[1];
    end
endmodule

// File: rtl/smallint_tag_unit_chk.sv
// Checker: port-level properties of the tag codec, bound to the top.
module smallint_tag_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [DATA_W-1:0] alu_res,
    input logic [DATA_W-1:0] opa_raw,
    input logic              opa_ok,
    input logic [DATA_W-1:0] opb_raw,
    input logic              opb_ok,
    input logic [DATA_W-1:0] res_word,
    input logic              res_ovf
);
    logic [1:0] seen;

    // Count clean edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)          seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    // R10: equal operands give equal lane outputs.
    assert_lanes_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && $past(opa) == $past(opb)) |->
            (opa_raw == opb_raw && opa_ok == opb_ok));

    // R3/R4: a zero operand always strips to zero.
    assert_zero_strip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && $past(opa) == '0) |-> (opa_raw == '0));

    // R5: a zero result rebuilds with only tag positions possibly set.
    assert_zero_rebuild_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && $past(alu_res) == '0) |-> (res_word[DATA_W-3:2] == '0));

    // R8: steady inputs and no recent write keep every output steady.
    assert_steady_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && $past(opa) == $past(opa, 2) && $past(opb) == $past(opb, 2)
         && $past(alu_res) == $past(alu_res, 2) && !$past(cfg_we, 2)) |->
            ($stable(opa_raw) && $stable(opb_raw) && $stable(res_word)
             && $stable(opa_ok) && $stable(opb_ok) && $stable(res_ovf)));
endmodule

bind smallint_tag_unit smallint_tag_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .opa      (opa),
    .opb      (opb),
    .alu_res  (alu_res),
    .opa_raw  (opa_raw),
    .opa_ok   (opa_ok),
    .opb_raw  (opb_raw),
    .opb_ok   (opb_ok),
    .res_word (res_word),
    .res_ovf  (res_ovf)
);

// File: tb/smallint_tag_unit_tb_top.sv
// Bench: behavioural reference model, compared after every clock.
module smallint_tag_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] opa = '0, opb = '0, alu_res = '0;
    logic [31:0] opa_raw, opb_raw, res_word;
    logic        opa_ok, opb_ok, res_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_cfg;

    always #(CLK_PERIOD / 2) clk = ~clk;

    smallint_tag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .opa(opa), .opb(opb), .alu_res(alu_res),
        .opa_raw(opa_raw), .opa_ok(opa_ok), .opb_raw(opb_raw), .opb_ok(opb_ok),
        .res_word(res_word), .res_ovf(res_ovf)
    );

    function automatic int tix(logic [31:0] w);
        return (w[31] ? 8 : 0) + (w[30] ? 4 : 0) + (w[1] ? 2 : 0) + (w[0] ? 1 : 0);
    endfunction

    function automatic logic [32:0] m_strip(logic [31:0] c, logic [31:0] w);
        logic [31:0] clr;
        longint v;
        int sh;
        clr = 32'h0;
        if (!c[19]) clr = clr | 32'h8000_0000;
        if (!c[18]) clr = clr | 32'h4000_0000;
        if (!c[17]) clr = clr | 32'h0000_0002;
        if (!c[16]) clr = clr | 32'h0000_0001;
        v = longint'($signed(w & ~clr));
        sh = int'(c[25:24]);
        for (int i = 0; i < sh; i++) v = (v < 0 && (v % 2 != 0)) ? (v - 1) / 2 : v / 2;
        return {c[tix(w)], v[31:0]};
    endfunction

    function automatic logic [32:0] m_build(logic [31:0] c, logic [31:0] r);
        longint p;
        logic [31:0] t;
        logic lost;
        p = longint'($signed(r)) * (longint'(1) << c[25:24]);
        lost = (p > 64'sd2147483647) || (p < -64'sd2147483648);
        t = p[31:0] | {c[23], c[22], 28'h0, c[21], c[20]};
        return {lost | ~c[tix(t)], t};
    endfunction

    // One cycle: drive at negedge, clock, compare at the next negedge.
    task automatic step(input logic we, input logic [31:0] wd, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] r, input string tag);
        logic [32:0] ea, eb, er;
        cfg_we = we; cfg_wdata = wd; opa = a; opb = b; alu_res = r;
        ea = m_strip(m_cfg, a);
        eb = m_strip(m_cfg, b);
        er = m_build(m_cfg, r);
        @(posedge clk);
        if (we) m_cfg = wd;
        @(negedge clk);
        n_cmp++;
        if ({opa_ok, opa_raw} !== ea || {opb_ok, opb_raw} !== eb || {res_ovf, res_word} !== er) begin
            n_bad++;
            $display("FAIL %s: got a=%b/%h b=%b/%h r=%b/%h exp a=%b/%h b=%b/%h r=%b/%h",
                tag, opa_ok, opa_raw, opb_ok, opb_raw, res_ovf, res_word,
                ea[32], ea[31:0], eb[32], eb[31:0], er[32], er[31:0]);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        m_cfg = 32'h000F_F00F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if ({opa_raw, opa_ok, opb_raw, opb_ok, res_word, res_ovf} !== '0) begin
            n_bad++;
            $display("FAIL R1: got %h/%h/%h expected zero outputs in reset", opa_raw, opb_raw, res_word);
        end
        rst_n = 1'b1;
        // R1 default convention, R7 illegal top bits on rebuild
        step(0, 0, 32'h4000_0000, 32'hC000_0005, 32'h3FFF_FFFF, "R1");
        step(0, 0, 32'h8000_0001, 32'h0000_0007, 32'h4000_0000, "R7");
        step(0, 0, 32'h0000_0000, 32'hFFFF_FFFF, 32'hBFFF_FFFF, "R7");
        // R9: spare bits set, same behaviour as default
        step(1, 32'hFC0F_F00F, 32'h1234_5678, 32'h7000_0000, 32'hC000_0000, "R9");
        step(0, 0, 32'h1234_5678, 32'h7000_0000, 32'hC000_0000, "R9");
        // R8: switch to odd-tag convention while operands are live
        step(1, 32'h011E_AAAA, 32'h0000_000B, 32'hFFFF_FFFF, 32'h0000_0005, "R8");
        step(0, 0, 32'h0000_000B, 32'hFFFF_FFFF, 32'h0000_0005, "R3");
        step(0, 0, 32'h0000_000A, 32'h8000_0001, 32'hFFFF_FFFF, "R4");
        step(0, 0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h7FFF_FFFF, "R6");
        step(0, 0, 32'h0000_0003, 32'h0000_0003, 32'h4000_0000, "R6");
        step(1, 32'h020F_1111, 32'h0000_0010, 32'hFFFF_FFF8, 32'h2000_0000, "R8");
        step(0, 0, 32'h0000_0010, 32'hFFFF_FFF8, 32'h2000_0000, "R6");
        step(0, 0, 32'h0000_0011, 32'h8000_0000, 32'hFFFF_FFFD, "R5");
        step(0, 0, 32'h1FFF_FFFC, 32'h0000_0002, 32'hE000_0000, "R4");
        // R2: one table entry at a time, walk all tag indices
        for (int k = 0; k < 16; k++) begin
            step(1, 32'h00F0_0000 | (32'h1 << k), 0, 0, 0, "R2");
            for (int j = 0; j < 16; j++) begin
                step(0, 0, {j[3], j[2], 26'h0, 2'b00, j[1], j[0]},
                     {j[3], j[2], 26'h155_5554, j[1], j[0]}, 32'h1, "R2");
            end
        end
        // R10/R8: random conventions and data, writes mixed with traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (n % 3 == 0) r = {{20{r[31]}}, r[11:0]};
            step(($urandom % 6) == 0, $urandom, $urandom, (n % 5 == 0) ? opa : $urandom,
                 r, "R10");
        end
        finish_run();
    end
endmodule